// File: doc/BRIEF.md
# Quarter-Rate Complex IQ Modulator

This block shifts a baseband complex signal up to a carrier at one quarter of the sample rate. Multiplying by a quarter-rate carrier only ever needs the factors 1, j, -1 and -j, so each sample is rotated by swapping and negating its I and Q words. No multipliers are used. A free-running two-bit phase counter picks the rotation. A one-cycle sync pulse pulls that counter back to phase zero, which lets several modulators, or a modulator and its matching demodulator, share one carrier phase.

A modulator enable selects between the rotated signal and a straight bypass of the input. Both routes run through the same two register stages, so the output always lags the input by exactly two clocks. Switching the enable therefore never shifts the data in time. A synchronous reset zeroes the outputs, the pipeline and the phase counter.

The data width is a parameter. It defaults to 16 bits and applies to both inputs and both outputs. The interface is plain data: one sample enters and one leaves on every clock, with no handshake.

Top module: `iq_qmod`

## Requirements
- R1: With the enable high and the sample captured at phase 0, the outputs two clocks later are I_out = I and Q_out = Q.
- R2: At phase 1 the outputs are I_out = -Q and Q_out = I.
- R3: At phase 2 the outputs are I_out = -I and Q_out = -Q.
- R4: At phase 3 the outputs are I_out = Q and Q_out = -I.
- R5: The phase counter advances by one, modulo 4, on every clock edge where sync is low and reset is low.
- R6: A clock edge with sync high loads the counter with 0. Sync takes priority over the increment, so holding sync high keeps the phase at 0.
- R7: With the enable low when a sample is captured, that sample leaves unchanged (I_out = I, Q_out = Q), whatever the phase.
- R8: A clock edge with reset high zeroes both outputs, clears both pipeline stages and sets the phase counter to 0. The two outputs that follow reset are therefore zero.
- R9: Latency from an input sample to its output is exactly two clocks, both in bypass and in modulated operation, including across a change of the enable.
- R10: Negating the most negative two's-complement value gives the most positive value (saturation), never a wrap.
- R11: A sample uses the counter value held in the cycle it is captured. A sample captured on the same edge as a sync pulse still uses the old phase, and the next sample uses phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | One-cycle pulse that sets the carrier phase to 0 |
| mod_en | input | 1 | 1 = rotate the sample, 0 = pass it through |
| i_in | input | W | Baseband in-phase sample, signed |
| q_in | input | W | Baseband quadrature sample, signed |
| i_out | output | W | Modulated in-phase sample, signed |
| q_out | output | W | Modulated quadrature sample, signed |

## Verification
The bench runs a 4-bit configuration through every I/Q pair in both enable states while the phase counter free-runs.

- **Counter and alignment:** sync pulses arrive at arbitrary points in the sweep. A counter that kept stepping through sync, or that was read one cycle late, would rotate every following sample by the wrong quarter turn.
- **Saturation:** the sweep reaches -8 in the negated lanes. A design that wrapped would output -8 where the expected value is +7.
- **Latency on enable changes:** directed impulses straddle enable changes. A bypass route one stage shorter would show up as output one clock early.
- **Reset:** a reset in mid-stream must flush both stages. A design that left one stage uncleared would leak a stale sample out after reset.

// File: rtl/iq_qmod_pkg.sv
package iq_qmod_pkg;
  localparam int PHASES = 4;
  localparam int PH_W = $clog2(PHASES);
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_ZERO = '0;
  localparam phase_t PH_QTR  = phase_t'(1);
  localparam phase_t PH_HALF = phase_t'(2);
  localparam phase_t PH_3QTR = phase_t'(3);
endpackage

// File: rtl/iq_qmod_phase.sv
module iq_qmod_phase
  import iq_qmod_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sync_in,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst)          phase <= PH_ZERO;
    else if (sync_in) phase <= PH_ZERO;
    else              phase <= phase + phase_t'(1);
  end
endmodule

// File: rtl/iq_qmod_satneg.sv
module iq_qmod_satneg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  always_comb begin
    if (a == MOST_NEG) y = MOST_POS;
    else               y = (~a) + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/iq_qmod_rotate.sv
module iq_qmod_rotate
  import iq_qmod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] i_d,
  input  logic [W-1:0] q_d,
  input  phase_t       phase,
  input  logic         en,
  output logic [W-1:0] i_r,
  output logic [W-1:0] q_r
);
  localparam int LANES = 2;
  logic [W-1:0] lane_in  [LANES];
  logic [W-1:0] lane_neg [LANES];

  assign lane_in[0] = i_d;
  assign lane_in[1] = q_d;

  for (genvar g = 0; g < LANES; g++) begin : g_neg
    iq_qmod_satneg #(.W(W)) u_neg (.a(lane_in[g]), .y(lane_neg[g]));
  end

  always_comb begin
    i_r = i_d;
    q_r = q_d;
    if (en) begin
      unique case (phase)
        PH_ZERO: begin i_r = i_d;         q_r = q_d;         end
        PH_QTR:  begin i_r = lane_neg[1]; q_r = i_d;         end
        PH_HALF: begin i_r = lane_neg[0]; q_r = lane_neg[1]; end
        default: begin i_r = q_d;         q_r = lane_neg[0]; end
      endcase
    end
  end
endmodule

// File: rtl/iq_qmod_stage.sv
module iq_qmod_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/iq_qmod.sv
module iq_qmod
  import iq_qmod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync_in,
  input  logic         mod_en,
  input  logic [W-1:0] i_in,
  input  logic [W-1:0] q_in,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out
);
  localparam int CAP_W = 1 + PH_W + 2 * W;
  localparam int OUT_W = 2 * W;

  phase_t ph_q;
  logic [CAP_W-1:0] cap_d, cap_q;
  logic [OUT_W-1:0] rot_d, rot_q;
  logic             en_s;
  phase_t           ph_s;
  logic [W-1:0]     i_s, q_s, i_r, q_r;

  iq_qmod_phase u_phase (.clk(clk), .rst(rst), .sync_in(sync_in), .phase(ph_q));

  // stage 1: the sample, its enable and the phase present in this cycle
  assign cap_d = {mod_en, ph_q, i_in, q_in};
  iq_qmod_stage #(.W(CAP_W)) u_cap (.clk(clk), .rst(rst), .d(cap_d), .q(cap_q));
  assign {en_s, ph_s, i_s, q_s} = cap_q;

  iq_qmod_rotate #(.W(W)) u_rot (
    .i_d(i_s), .q_d(q_s), .phase(ph_s), .en(en_s), .i_r(i_r), .q_r(q_r)
  );

  // stage 2: output register, shared by bypass and rotated data
  assign rot_d = {i_r, q_r};
  iq_qmod_stage #(.W(OUT_W)) u_out (.clk(clk), .rst(rst), .d(rot_d), .q(rot_q));
  assign {i_out, q_out} = rot_q;
endmodule

// File: rtl/iq_qmod_chk.sv
module iq_qmod_chk
  import iq_qmod_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sync_in,
  input logic         mod_en,
  input logic [W-1:0] i_in,
  input logic [W-1:0] q_in,
  input logic [W-1:0] i_out,
  input logic [W-1:0] q_out,
  input phase_t       ph
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (i_out == '0 && q_out == '0 && ph == PH_ZERO));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && !$past(sync_in)) |-> ph == phase_t'($past(ph) + phase_t'(1)));

  p_sync_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(sync_in)) |-> ph == PH_ZERO);

  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && !$past(mod_en, 2)) |->
      (i_out == $past(i_in, 2) && q_out == $past(q_in, 2)));

  p_phase0_r1: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(mod_en, 2) && $past(ph, 2) == PH_ZERO) |->
      (i_out == $past(i_in, 2) && q_out == $past(q_in, 2)));

  p_phase1_r2: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(mod_en, 2) && $past(ph, 2) == PH_QTR &&
     $past(q_in, 2) != MOST_NEG) |->
      (i_out == W'(0 - $past(q_in, 2)) && q_out == $past(i_in, 2)));

  p_phase2_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(mod_en, 2) && $past(ph, 2) == PH_HALF &&
     $past(i_in, 2) != MOST_NEG && $past(q_in, 2) != MOST_NEG) |->
      (i_out == W'(0 - $past(i_in, 2)) && q_out == W'(0 - $past(q_in, 2))));

  p_phase3_r4: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(mod_en, 2) && $past(ph, 2) == PH_3QTR &&
     $past(i_in, 2) != MOST_NEG) |->
      (i_out == $past(q_in, 2) && q_out == W'(0 - $past(i_in, 2))));

  p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(mod_en, 2) && $past(ph, 2) == PH_HALF &&
     $past(i_in, 2) == MOST_NEG) |-> i_out == MOST_POS);
endmodule

bind iq_qmod iq_qmod_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .mod_en(mod_en),
  .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out), .ph(ph_q)
);

// File: tb/sim_iq_qmod.sv
module sim_iq_qmod;
  localparam int W = 4;
  localparam int VMIN = -(1 << (W - 1));
  localparam int VMAX = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic mod_en = 1'b0;
  logic [W-1:0] i_in = '0, q_in = '0;
  logic [W-1:0] i_out, q_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iq_qmod #(.W(W)) u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .mod_en(mod_en),
    .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out)
  );

  // expectation pipeline derived from the requirements
  int e1i = 0, e1q = 0, e2i = 0, e2q = 0, mph = 0;
  string t1 = "R8", t2 = "R8";

  function automatic int sneg(input int v);
    return (v == VMIN) ? VMAX : -v;
  endfunction

  task automatic check(input int ei, input int eq, input string tag);
    int ai = $signed(i_out);
    int aq = $signed(q_out);
    checks++;
    if (ai != ei || aq != eq) begin
      failures++;
      $display("FAIL %s: out=(%0d,%0d) expected=(%0d,%0d)", tag, ai, aq, ei, eq);
    end
  endtask

  task automatic tick(input int ii, input int qq, input bit en, input bit sy,
                      input bit r, input string tag);
    int oi, oq;
    string dt;
    i_in = W'(ii); q_in = W'(qq); mod_en = en; sync_in = sy; rst = r;
    @(posedge clk);
    if (r) begin
      e1i = 0; e1q = 0; e2i = 0; e2q = 0; mph = 0;
      t1 = (tag != "") ? tag : "R8"; t2 = t1;
    end else begin
      e2i = e1i; e2q = e1q; t2 = t1;
      oi = ii; oq = qq;
      if (!en) dt = "R7";
      else begin
        case (mph)
          0: begin oi = ii;       oq = qq;       dt = "R1"; end
          1: begin oi = sneg(qq); oq = ii;       dt = (qq == VMIN) ? "R10" : "R2"; end
          2: begin oi = sneg(ii); oq = sneg(qq); dt = (ii == VMIN || qq == VMIN) ? "R10" : "R3"; end
          default: begin oi = qq; oq = sneg(ii); dt = (ii == VMIN) ? "R10" : "R4"; end
        endcase
      end
      e1i = oi; e1q = oq; t1 = (tag != "") ? tag : dt;
      mph = sy ? 0 : (mph + 1) % 4;
    end
    @(negedge clk);
    check(e2i, e2q, t2);
  endtask

  initial begin
    @(negedge clk);
    // R8: reset state
    tick(3, 2, 1, 0, 1, "R8");
    tick(3, 2, 1, 0, 1, "R8");
    // R5: counter steps through all phases after a sync
    tick(0, 0, 1, 1, 0, "R5");
    for (int k = 0; k < 8; k++) tick(3, 1, 1, 0, 0, "R5");
    // R6: sync held two cycles keeps phase 0
    tick(2, 1, 1, 1, 0, "R6");
    tick(2, 1, 1, 1, 0, "R6");
    tick(2, 1, 1, 0, 0, "R6");
    tick(2, 1, 1, 0, 0, "R6");
    // R11: sample on the sync edge uses the old phase; next uses phase 0
    tick(0, 0, 1, 0, 0, "R11");
    tick(5, -3, 1, 1, 0, "R11");
    tick(5, -3, 1, 0, 0, "R11");
    tick(5, -3, 1, 0, 0, "R11");
    // R9: impulses across enable changes, latency must stay two clocks
    for (int k = 0; k < 3; k++) tick(0, 0, 0, 0, 0, "R9");
    tick(6, -2, 0, 0, 0, "R9");
    tick(0, 0, 1, 0, 0, "R9");
    tick(-5, 4, 1, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, "R9");
    // R8: reset in mid-stream flushes the pipeline and the counter
    tick(7, 7, 1, 0, 0, "");
    tick(-7, 6, 1, 0, 0, "");
    tick(1, 1, 1, 0, 1, "R8");
    tick(4, 3, 1, 0, 0, "");
    tick(4, 3, 1, 0, 0, "");
    // R1-to-R4 mapping, R7 bypass, R10 saturation: exhaustive sweep
    for (int e = 1; e >= 0; e--)
      for (int a = VMIN; a <= VMAX; a++)
        for (int b = VMIN; b <= VMAX; b++)
          tick(a, b, e[0], ((a * 16 + b) % 37) == 0, 0, "");
    tick(0, 0, 0, 0, 0, "");
    tick(0, 0, 0, 0, 0, "");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule